// File: doc/BRIEF.md
# Converter Power Mode Controller

This block is a finite-state controller that sets the power state of a data converter. It reads two bits of a configuration word and decodes strobed command words. From these it drives registered enables for the oscillator, the bias generator, the analog front end and the decimation filter, plus a low-power indication, a ready flag and a 2-bit mode code.

There are four modes. Normal and low power are the active modes, and configuration bit 16 chooses between them. Standby and sleep are the power-save modes, and configuration bit 4 chooses which one a power-save command enters. Standby keeps the oscillator and bias running, so a wake command returns the block to active on the next clock. Sleep stops the oscillator. A wake from sleep first turns the oscillator on, then waits `WAKE_TICKS` pulses of an always-on timebase tick before the block is ready again. The default of 16384 ticks is about 500 ms at a 32.768 kHz timebase.

States: ACTIVE, STANDBY, SLEEP, WAKE. Transitions:
- ACTIVE to STANDBY on a save command while cfg[4]=0.
- ACTIVE to SLEEP on a save command while cfg[4]=1.
- STANDBY to ACTIVE on a wake command.
- SLEEP to WAKE on a wake command.
- WAKE to ACTIVE when the tick count expires.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held, and immediately after it, the block is in normal mode. The mode code is 0, all four enables are 1, ready is 1 and low_power is 0.
- R2: While active, cfg[16]=1 selects low power (mode 1, low_power 1) and cfg[16]=0 selects normal (mode 0). A change to cfg[16] appears at the outputs after the next clock edge, and not before it.
- R3: A command is accepted only in a cycle where cmd_valid is 1. A save command has cmd_word[3]=1 and cmd_word[7]=1. A wake command has cmd_word[3]=1 and cmd_word[7]=0. Any word with cmd_word[3]=0 has no effect.
- R4: A save command while active with cfg[4]=0 enters standby on the next edge. In standby the mode is 2, osc_en and bias_en are 1, analog_en and filter_en are 0, and low_power and ready are 0.
- R5: A save command while active with cfg[4]=1 enters sleep on the next edge. In sleep the mode is 3 and all enables, low_power and ready are 0.
- R6: A wake command in standby returns the block to active on the next edge, with no tick wait. The active mode is chosen by cfg[16].
- R7: A wake command in sleep asserts osc_en at the next edge. From then, the mode stays 3, ready stays 0 and the other enables stay 0, until the edge that samples the WAKE_TICKS-th tick after the request. At that edge the block becomes active.
- R8: All commands, including save commands, are ignored while the wake count runs.
- R9: The active mode entered at the end of a wake from sleep uses the value cfg[16] had when the wake command was taken. After that, the mode follows cfg[16] again.
- R10: A wake command while active is ignored. A save command while in standby or sleep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Always-on timebase pulse, one clk cycle wide |
| cfg | input | CFG_W | Configuration word; bit 16 selects low power, bit 4 selects sleep |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | CMD_W | Command word; bit 3 is save/resume, bit 7 is the command marker |
| osc_en | output | 1 | Oscillator enable |
| bias_en | output | 1 | Bias generator enable |
| analog_en | output | 1 | Analog front-end enable |
| filter_en | output | 1 | Decimation filter enable |
| low_power | output | 1 | Low-power mode indication |
| ready | output | 1 | Converter ready flag |
| mode | output | 2 | 0 normal, 1 low power, 2 standby, 3 sleep |

## Verification
The bench sweeps every combination of cfg[16], cfg[4] and the two command bits from the active state. It then follows each power-save entry through an ignored command and a wake.

Several faults are targeted:
- Taking a word with only the marker bit set as a save command would put the block into power save when it should stay active.
- Ending the wake count one tick early or one tick late would raise ready a tick too soon or too late.
- Honouring a save command during the count would send the block back to sleep.
- Reading the live cfg[16] when the count expires, instead of the value latched at the wake request, would show the wrong active mode on the first cycle after wake-up.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_LOWPWR  = 2'd1,
        MODE_STANDBY = 2'd2,
        MODE_SLEEP   = 2'd3
    } mode_code_t;

    typedef enum logic [1:0] {
        ST_ACTIVE,
        ST_STANDBY,
        ST_SLEEP,
        ST_WAKE
    } pstate_t;

    typedef struct packed {
        logic       osc;
        logic       bias;
        logic       analog;
        logic       filter;
        logic       low_power;
        logic       ready;
        mode_code_t mode;
    } pwr_out_t;

    localparam pwr_out_t OUT_RESET = '{osc: 1'b1, bias: 1'b1, analog: 1'b1,
                                       filter: 1'b1, low_power: 1'b0,
                                       ready: 1'b1, mode: MODE_NORMAL};

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode #(
    parameter int CMD_W    = 8,
    parameter int SAVE_BIT = 3,
    parameter int MARK_BIT = 7
) (
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             save_req,
    output logic             wake_req
);
    localparam logic [CMD_W-1:0] USED_MASK = (CMD_W'(1) << SAVE_BIT) | (CMD_W'(1) << MARK_BIT);

    logic cmd_unused;
    assign cmd_unused = ^(cmd_word & ~USED_MASK);

    always_comb begin
        save_req = cmd_valid & cmd_word[SAVE_BIT] &  cmd_word[MARK_BIT];
        wake_req = cmd_valid & cmd_word[SAVE_BIT] & ~cmd_word[MARK_BIT];
    end
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int WAKE_TICKS = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(WAKE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_TICKS - 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAKE_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run & tick & (cnt == LAST);

    // R7: the tick count never passes the wake length
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < LIMIT));

    // R7: the count restarts from zero for each new wake
    a_r7_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     save_req,
    input  logic     wake_req,
    input  logic     expire,
    input  logic     lp_sel,
    input  logic     sleep_sel,
    output logic     waking,
    output pwr_out_t out_q
);
    pstate_t  state, nxt;
    logic     target_lp;
    logic     lp_eff;
    pwr_out_t out_d;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ACTIVE:  if (save_req) nxt = sleep_sel ? ST_SLEEP : ST_STANDBY;
            ST_STANDBY: if (wake_req) nxt = ST_ACTIVE;
            ST_SLEEP:   if (wake_req) nxt = ST_WAKE;
            ST_WAKE:    if (expire)   nxt = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_ACTIVE;
            target_lp <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_SLEEP && wake_req) target_lp <= lp_sel;
        end
    end

    always_comb begin
        lp_eff = (state == ST_WAKE) ? target_lp : lp_sel;
        out_d  = '0;
        unique case (nxt)
            ST_ACTIVE: begin
                out_d.osc       = 1'b1;
                out_d.bias      = 1'b1;
                out_d.analog    = 1'b1;
                out_d.filter    = 1'b1;
                out_d.ready     = 1'b1;
                out_d.low_power = lp_eff;
                out_d.mode      = lp_eff ? MODE_LOWPWR : MODE_NORMAL;
            end
            ST_STANDBY: begin
                out_d.osc  = 1'b1;
                out_d.bias = 1'b1;
                out_d.mode = MODE_STANDBY;
            end
            ST_SLEEP: begin
                out_d.mode = MODE_SLEEP;
            end
            ST_WAKE: begin
                out_d.osc  = 1'b1;
                out_d.mode = MODE_SLEEP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= OUT_RESET;
        else        out_q <= out_d;
    end

    assign waking = (state == ST_WAKE);

    // R3: one word is never both a save and a wake
    a_r3_decode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(save_req && wake_req));

    // R4: standby keeps the oscillator and bias on, the filter off
    a_r4_standby_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.mode == MODE_STANDBY) |-> (out_q.osc && out_q.bias && !out_q.filter && !out_q.ready));

    // R5: sleep state shows every enable off
    a_r5_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |-> (!out_q.osc && !out_q.bias && !out_q.analog && !out_q.filter));

    // R7: while counting, oscillator on and not ready
    a_r7_ready_low_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> (out_q.osc && !out_q.ready && out_q.mode == MODE_SLEEP));

    // R8: nothing but the expiry ends the wake count
    a_r8_wake_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && !expire) |=> (state == ST_WAKE));

    // R10: a wake command cannot move the active state
    a_r10_active_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !save_req) |=> (state == ST_ACTIVE));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int CFG_W      = 24,
    parameter int LP_BIT     = 16,
    parameter int SLEEP_BIT  = 4,
    parameter int CMD_W      = 8,
    parameter int SAVE_BIT   = 3,
    parameter int MARK_BIT   = 7,
    parameter int WAKE_TICKS = 16384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CFG_W-1:0] cfg,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             osc_en,
    output logic             bias_en,
    output logic             analog_en,
    output logic             filter_en,
    output logic             low_power,
    output logic             ready,
    output logic [1:0]       mode
);
    localparam logic [CFG_W-1:0] CFG_MASK = (CFG_W'(1) << LP_BIT) | (CFG_W'(1) << SLEEP_BIT);

    logic     cfg_unused;
    logic     save_req, wake_req, expire, waking;
    pwr_out_t out_q;

    assign cfg_unused = ^(cfg & ~CFG_MASK);

    pwr_cmd_decode #(.CMD_W(CMD_W), .SAVE_BIT(SAVE_BIT), .MARK_BIT(MARK_BIT)) i_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .save_req  (save_req),
        .wake_req  (wake_req)
    );

    pwr_wake_timer #(.WAKE_TICKS(WAKE_TICKS)) i_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (waking),
        .tick   (tick),
        .expire (expire)
    );

    pwr_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .save_req  (save_req),
        .wake_req  (wake_req),
        .expire    (expire),
        .lp_sel    (cfg[LP_BIT]),
        .sleep_sel (cfg[SLEEP_BIT]),
        .waking    (waking),
        .out_q     (out_q)
    );

    assign osc_en    = out_q.osc;
    assign bias_en   = out_q.bias;
    assign analog_en = out_q.analog;
    assign filter_en = out_q.filter;
    assign low_power = out_q.low_power;
    assign ready     = out_q.ready;
    assign mode      = out_q.mode;

    // R2: low-power flag agrees with the active mode code
    a_r2_lp_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (low_power == (mode == 2'd1)));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [23:0] cfg = '0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_word = '0;
    logic        osc_en, bias_en, analog_en, filter_en, low_power, ready;
    logic [1:0]  mode;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.WAKE_TICKS(NT)) i_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .osc_en(osc_en), .bias_en(bias_en), .analog_en(analog_en),
        .filter_en(filter_en), .low_power(low_power), .ready(ready), .mode(mode)
    );

    // packed view: {osc,bias,analog,filter,low_power,ready,mode}
    function automatic logic [7:0] exp_out(int m);
        case (m)
            0: return 8'hF4;
            1: return 8'hFD;
            2: return 8'hC2;
            3: return 8'h03;
            default: return 8'h83; // waking from sleep
        endcase
    endfunction

    task automatic check(string req, logic [7:0] exp);
        logic [7:0] act;
        act = {osc_en, bias_en, analog_en, filter_en, low_power, ready, mode};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic send_cmd(bit mark, bit save);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = {mark, 3'b010, save, 3'b101};
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state, even with low power selected
        cfg[16] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 during reset", exp_out(0));
        @(negedge clk) rst_n = 1'b1;
        check("R1 after reset", exp_out(0));

        // R2 change takes one edge
        @(negedge clk);
        check("R2 low power selected", exp_out(1));
        cfg[16] = 1'b0;
        #1 check("R2 not before edge", exp_out(1));
        @(negedge clk);
        check("R2 normal selected", exp_out(0));

        // sweep of configuration and command bits from active
        for (int lp = 0; lp < 2; lp++) begin
            for (int sl = 0; sl < 2; sl++) begin
                for (int c = 0; c < 4; c++) begin
                    bit mk, sv;
                    int target;
                    mk = c[1];
                    sv = c[0];
                    do_reset();
                    cfg = '0;
                    cfg[16] = lp[0];
                    cfg[4]  = sl[0];
                    @(negedge clk);
                    check("R2 active", exp_out(lp));
                    send_cmd(mk, sv);
                    target = (mk && sv) ? (sl ? 3 : 2) : lp;
                    if (!(mk && sv)) check(mk ? "R3 marker only ignored" : (sv ? "R10 wake while active" : "R3 empty word ignored"), exp_out(target));
                    else check(sl ? "R5 sleep entry" : "R4 standby entry", exp_out(target));
                    if (mk && sv) begin
                        send_cmd(1'b1, 1'b1);
                        check("R10 save in power save ignored", exp_out(target));
                        send_cmd(1'b1, 1'b0);
                        check("R3 word without save bit ignored", exp_out(target));
                        send_cmd(1'b0, 1'b1);
                        if (!sl) begin
                            check("R6 standby instant return", exp_out(lp));
                        end else begin
                            check("R7 oscillator on at wake request", exp_out(4));
                            for (int k = 1; k <= NT; k++) begin
                                if (k == 2) begin
                                    send_cmd(1'b1, 1'b1);
                                    check("R8 save ignored while counting", exp_out(4));
                                    send_cmd(1'b0, 1'b1);
                                    check("R8 wake ignored while counting", exp_out(4));
                                end
                                pulse_tick();
                                check(k < NT ? "R7 still counting" : "R7 active after last tick",
                                      exp_out(k < NT ? 4 : lp));
                            end
                        end
                    end
                end
            end
        end

        // R9 target latched at the wake request
        do_reset();
        cfg = '0;
        cfg[4] = 1'b1;
        @(negedge clk);
        send_cmd(1'b1, 1'b1);
        check("R5 sleep before R9", exp_out(3));
        send_cmd(1'b0, 1'b1);
        cfg[16] = 1'b1;
        for (int k = 1; k <= NT; k++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            if (k < NT) check("R9 counting", exp_out(4));
        end
        check("R9 latched normal at wake end", exp_out(0));
        @(negedge clk);
        check("R9 follows cfg afterwards", exp_out(1));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule